// File: doc/BRIEF.md
# Video Clamp Strobe Generator

This block produces the strobe that tells the analog front end of a three-channel video digitizer when to clamp its inputs. It also carries three per-channel level selects that choose the clamp target for each channel: ground or midscale. It runs on the pixel clock.

In internal timing mode the block finds the leading edge of horizontal sync, waits a programmable number of pixel clocks, and then holds the strobe for a programmable number of pixel clocks. In external timing mode a dedicated clamp pin drives the strobe through a selectable polarity stage. One strobe serves all three channels.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `clamp_o` and `lvl_o` are 0 and the source is internal timing, whatever the value of `clamp_src_ext`.
- R2: The leading edge of sync is a clock edge at which sync is sampled active and was not active at the previous sample. Sync is active high when `hsync_act_high` is 1 and active low when it is 0. The previous sample counts as active just after reset.
- R3: In internal mode, let a leading edge be detected at clock edge k, with placement P and duration D sampled at edge k. If D is non-zero, `clamp_o` is 1 after clock edges k+P through k+P+D-1 and 0 at all other times.
- R4: A duration of 0 sampled at a leading edge produces no pulse, and it ends any pulse already in progress.
- R5: A new leading edge that arrives while a placement wait or a pulse is running restarts the sequence from that edge, using the new placement and duration.
- R6: In external mode, after each clock edge `clamp_o` equals `clamp_ext` as sampled at that edge when `clamp_ext_act_high` is 1, and equals the inverse of `clamp_ext` when it is 0.
- R7: A change of `clamp_src_ext` takes effect at the next clock edge: 1 selects the external pin and 0 selects internal timing. The internal counters keep running in external mode.
- R8: `lvl_o` follows `lvl_sel` one clock later. Bit 2 is red, bit 1 is green and bit 0 is blue. A 0 means clamp to ground and a 1 means clamp to midscale.
- R9: With a placement of 0 and a non-zero duration, `clamp_o` rises right after the clock edge that detects the leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync |
| hsync_act_high | input | 1 | 1 when sync is active high |
| clamp_ext | input | 1 | External clamp pin |
| clamp_ext_act_high | input | 1 | 1 when the external clamp pin is active high |
| clamp_src_ext | input | 1 | 1 selects the external pin, 0 selects internal timing |
| place_cnt | input | CW | Delay from the sync edge to the start of the strobe, in clocks |
| dur_cnt | input | CW | Strobe length in clocks; 0 means no strobe |
| lvl_sel | input | 3 | Clamp level requests for red, green and blue |
| clamp_o | output | 1 | Clamp strobe shared by the three channels |
| lvl_o | output | 3 | Registered level selects for red, green and blue |

## Verification
Every result depends on the inputs present at a given clock edge. The pin path, the source select and the level selects appear one clock later. The internal strobe starts P edges after the edge that detects sync and lasts D edges. The bench keeps a count of clock edges and records the edge index of the latest detected sync edge, together with the placement and duration captured there. After each rising edge it waits for the falling edge, then compares the outputs with a window computed from that edge index. New stimulus is driven only after that comparison.

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          hsync_act_high,
  input  logic          clamp_ext,
  input  logic          clamp_ext_act_high,
  input  logic          clamp_src_ext,
  input  logic [CW-1:0] place_cnt,
  input  logic [CW-1:0] dur_cnt,
  input  logic [2:0]    lvl_sel,
  output logic          clamp_o,
  output logic [2:0]    lvl_o
);
  typedef enum logic [1:0] {IDLE, WAIT, PULSE} st_t;

  st_t           st;
  logic [CW-1:0] cnt, dur_q;
  logic          hs_q, ext_q, src_q;
  logic          hs_act, hs_edge;

  assign hs_act  = hsync_act_high ? hsync : ~hsync;
  assign hs_edge = hs_act & ~hs_q;
  assign clamp_o = src_q ? ext_q : (st == PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      dur_q <= '0;
      hs_q  <= 1'b1;
      ext_q <= 1'b0;
      src_q <= 1'b0;
      lvl_o <= 3'b000;
    end else begin
      hs_q  <= hs_act;
      ext_q <= clamp_ext_act_high ? clamp_ext : ~clamp_ext;
      src_q <= clamp_src_ext;
      lvl_o <= lvl_sel;
      if (hs_edge) begin
        dur_q <= dur_cnt;
        if (dur_cnt == '0) begin
          st  <= IDLE;
          cnt <= '0;
        end else if (place_cnt == '0) begin
          st  <= PULSE;
          cnt <= dur_cnt - 1'b1;
        end else begin
          st  <= WAIT;
          cnt <= place_cnt - 1'b1;
        end
      end else begin
        case (st)
          WAIT:
            if (cnt == '0) begin
              st  <= PULSE;
              cnt <= dur_q - 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          PULSE:
            if (cnt == '0) st <= IDLE;
            else cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
module clamp_pulse_gen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_edge,
  input logic          clamp_ext,
  input logic          clamp_ext_act_high,
  input logic          clamp_src_ext,
  input logic [CW-1:0] place_cnt,
  input logic [CW-1:0] dur_cnt,
  input logic [2:0]    lvl_sel,
  input logic          clamp_o,
  input logic [2:0]    lvl_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (clamp_o == 1'b0 && lvl_o == 3'b000));

  // R6
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_src_ext |=> clamp_o == $past(clamp_ext_act_high ? clamp_ext : ~clamp_ext));

  // R4
  zero_dur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge && dur_cnt == '0 && !clamp_src_ext) |=> !clamp_o);

  // R9
  zero_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge && place_cnt == '0 && dur_cnt != '0 && !clamp_src_ext) |=> clamp_o);

  // R8
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl_o == $past(lvl_sel));
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .clamp_ext(clamp_ext),
  .clamp_ext_act_high(clamp_ext_act_high), .clamp_src_ext(clamp_src_ext),
  .place_cnt(place_cnt), .dur_cnt(dur_cnt), .lvl_sel(lvl_sel),
  .clamp_o(clamp_o), .lvl_o(lvl_o)
);

// File: tb/clamp_pulse_gen_bench.sv
`timescale 1ns/1ps
module clamp_pulse_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync = 1'b0, hs_pol = 1'b1, ext = 1'b0, ext_pol = 1'b1, src = 1'b0;
  logic [7:0] place = 8'd0, dur = 8'd0;
  logic [2:0] lvl = 3'b000;
  logic clamp_o;
  logic [2:0] lvl_o;

  int n_chk = 0, n_fail = 0;
  int n = 0, k = -1, eP = 0, eD = 0;
  bit prev = 1'b1, x_src = 1'b0, x_ext = 1'b0;
  logic [2:0] x_lvl = 3'b000;
  string req = "R1";

  always #2 clk = ~clk;

  clamp_pulse_gen u_clamp_pulse_gen (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .hsync_act_high(hs_pol),
    .clamp_ext(ext), .clamp_ext_act_high(ext_pol), .clamp_src_ext(src),
    .place_cnt(place), .dur_cnt(dur), .lvl_sel(lvl),
    .clamp_o(clamp_o), .lvl_o(lvl_o));

  function automatic bit int_window(int cyc, int edge_at, int p, int d);
    return edge_at >= 0 && d != 0 && (cyc - edge_at) >= p && (cyc - edge_at) < p + d;
  endfunction

  task automatic chk(string r, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d exp %0d at cycle %0d", r, what, got, exp, n);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic step();
    bit act;
    @(posedge clk);
    n++;
    act = hs_pol ? hsync : ~hsync;
    if (act && !prev) begin k = n; eP = int'(place); eD = int'(dur); end
    prev = act;
    x_src = src;
    x_ext = ext_pol ? ext : ~ext;
    x_lvl = lvl;
    @(negedge clk);
    chk(x_src ? "R6" : req, "clamp", int'(clamp_o),
        int'(x_src ? x_ext : int_window(n, k, eP, eD)));
    chk("R8", "lvl", int'(lvl_o), int'(x_lvl));
  endtask

  task automatic line(int hi, int lo);
    hsync = hs_pol; repeat (hi) step();
    hsync = ~hs_pol; repeat (lo) step();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset holds outputs low even with external source requested
    src = 1'b1; ext = 1'b1; lvl = 3'b111;
    repeat (3) @(negedge clk);
    chk("R1", "clamp in reset", int'(clamp_o), 0);
    chk("R1", "lvl in reset", int'(lvl_o), 0);
    src = 1'b0; ext = 1'b0; lvl = 3'b000;
    rst_n = 1'b1;

    req = "R3"; place = 8'd5; dur = 8'd4; line(10, 30);
    place = 8'd12; dur = 8'd1; line(3, 30);
    req = "R9"; place = 8'd0; dur = 8'd3; line(2, 20);
    req = "R4"; place = 8'd2; dur = 8'd0; line(4, 20);
    place = 8'd1; dur = 8'd20; line(2, 4);
    dur = 8'd0; line(2, 30);
    req = "R5"; place = 8'd20; dur = 8'd5; line(2, 8);
    place = 8'd3; dur = 8'd6; line(2, 30);
    req = "R2"; hs_pol = 1'b0; hsync = 1'b1; step();
    place = 8'd4; dur = 8'd3; line(5, 25);
    hs_pol = 1'b1; line(5, 25);
    req = "R6"; src = 1'b1;
    for (int i = 0; i < 40; i++) begin
      ext = 1'(i % 3 == 0); ext_pol = 1'(i >= 20); step();
    end
    req = "R7"; src = 1'b0; place = 8'd1; dur = 8'd10; hsync = 1'b1; step();
    src = 1'b1; step(); step(); src = 1'b0; hsync = 1'b0; repeat (15) step();
    req = "R8";
    for (int i = 0; i < 8; i++) begin lvl = 3'(i); step(); end

    req = "R3";
    for (int ln = 0; ln < 120; ln++) begin
      place = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom_range(1, 80));
      dur = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom_range(1, 60));
      if ($urandom_range(0, 15) == 0) begin place = 8'd255; dur = 8'd255; end
      if ($urandom_range(0, 7) == 0) hs_pol = ~hs_pol;
      hsync = ~hs_pol;
      for (int c = 0; c < int'($urandom_range(20, 500)); c++) begin
        if (c == 2) hsync = hs_pol;
        if (c == int'($urandom_range(4, 12))) hsync = ~hs_pol;
        if ($urandom_range(0, 63) == 0) src = ~src;
        ext = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 99) == 0) ext_pol = ~ext_pol;
        if ($urandom_range(0, 31) == 0) lvl = 3'($urandom_range(0, 7));
        step();
      end
    end
    summary();
    $finish;
  end
endmodule